// File: doc/BRIEF.md
# Oldest-First Crossbar Destination Arbiter

This block guards one destination port of a crossbar in which many requesters, such as processor cores, share a smaller set of targets, such as cache banks. Each requester pushes packets meant for this destination over its own valid/ready channel. A push carries a kind bit and two beats of payload. The block keeps up to two such packets per requester. It always sends the packet that has been waiting longest, and it presents that packet on a single output stream with valid/ready flow control.

A packet takes three steps. In the request cycle it is pushed. In the arbitration cycle it sits at the head of its requester's queue and competes. In the transmit cycle it appears on the output. Age comes from a timestamp, which is a free-running cycle counter sampled when the packet is pushed. When two packets are equally old, the lower requester index wins. A line-kind packet is sent as two beats. The second beat follows the first on the very next cycle with no gap, and the port stays reserved for that requester between the two beats.

Top module: `xbar_age_arb`

## Requirements
- R1: `req_ready[i]` is low while requester i holds two pending packets. A push offered while it is low is ignored and never reaches the output.
- R2: If a packet is pushed at clock edge E into an idle port with `out_ready` high, `out_valid` stays low in the cycle after E and goes high in the cycle after edge E+1.
- R3: Among all pending packets, the one pushed at the earliest edge is sent first, whatever its requester index.
- R4: Packets pushed at the same edge by different requesters are sent in ascending requester index.
- R5: `req_kind` = 1 marks a line packet. It is sent as beat 0 (`req_data` bits [BEAT_W-1:0], `out_last` = 0) and then beat 1 (bits [2*BEAT_W-1:BEAT_W], `out_last` = 1). Beat 1 is valid in the cycle right after beat 0 is accepted, with the same `out_src`.
- R6: No beat from another requester is placed between the two beats of a line packet, and the queues release at most one packet per cycle.
- R7: While `out_valid` is high and `out_ready` is low, `out_data`, `out_src` and `out_last` hold their values.
- R8: The packets of one requester leave in the order that requester pushed them.
- R9: During and right after reset, `out_valid` is 0 and every `req_ready` bit is 1.
- R10: `req_kind` = 0 marks a word packet. It is sent as one beat carrying bits [BEAT_W-1:0] with `out_last` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_REQ | Push request per requester |
| req_ready | output | NUM_REQ | Per-requester queue has room |
| req_kind | input | NUM_REQ | Packet kind per requester: 0 word, 1 line |
| req_data | input | NUM_REQ*2*BEAT_W | Two beats per requester; requester i uses slice i |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Destination accepts the beat |
| out_data | output | BEAT_W | Output beat payload |
| out_last | output | 1 | Final beat of the packet |
| out_src | output | $clog2(NUM_REQ) | Requester the beat came from |

## Verification
The assertions check on every cycle that a stalled output holds its beat, that the second beat of a line packet follows the accepted first beat at once from the same source, that the port stays locked while a first beat is outstanding, that at most one queue pops per cycle, and that the port comes out of reset idle and ready. Other behaviours need the bench's scenarios: oldest-first order across requesters, the index tie-break, per-requester FIFO order, the refusal of a third push, the three-step latency and the exact payload of each beat. These involve the history of pushes, so only a scoreboard that rebuilds the expected order from push times can show them.

// File: rtl/xarb_pkg.sv
package xarb_pkg;

  typedef enum logic {
    KIND_WORD = 1'b0,
    KIND_LINE = 1'b1
  } pkt_kind_e;

  // Modular age of an entry: cycles elapsed since its stamp.
  function automatic logic [31:0] stamp_age(input logic [31:0] now,
                                            input logic [31:0] stamp,
                                            input int unsigned w);
    logic [31:0] mask;
    mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (now - stamp) & mask;
  endfunction

endpackage

// File: rtl/xarb_pair_fifo.sv
module xarb_pair_fifo #(
  parameter int PAY_W = 256,
  parameter int TS_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             push_kind,
  input  logic [PAY_W-1:0] push_data,
  input  logic [TS_W-1:0]  push_ts,
  input  logic             pop,
  output logic             head_valid,
  output logic             head_kind,
  output logic [PAY_W-1:0] head_data,
  output logic [TS_W-1:0]  head_ts,
  output logic             full
);
  localparam int DEPTH = 2;

  logic [PAY_W-1:0] slot_data [DEPTH];
  logic             slot_kind [DEPTH];
  logic [TS_W-1:0]  slot_ts   [DEPTH];
  logic             rd_ptr, wr_ptr;
  logic [1:0]       count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= 1'b0;
      wr_ptr <= 1'b0;
      count  <= 2'd0;
    end else begin
      if (push) wr_ptr <= ~wr_ptr;
      if (pop)  rd_ptr <= ~rd_ptr;
      count <= count + {1'b0, push} - {1'b0, pop};
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      slot_data[wr_ptr] <= push_data;
      slot_kind[wr_ptr] <= push_kind;
      slot_ts[wr_ptr]   <= push_ts;
    end
  end

  assign head_valid = (count != 2'd0);
  assign head_kind  = slot_kind[rd_ptr];
  assign head_data  = slot_data[rd_ptr];
  assign head_ts    = slot_ts[rd_ptr];
  assign full       = (count == 2'(DEPTH));
endmodule

// File: rtl/xarb_oldest_pick.sv
module xarb_oldest_pick #(
  parameter int NUM_REQ = 8,
  parameter int TS_W    = 16,
  parameter int SRC_W   = 3
) (
  input  logic [TS_W-1:0]         now,
  input  logic [NUM_REQ-1:0]      cand_valid,
  input  logic [NUM_REQ*TS_W-1:0] cand_ts,
  output logic                    win_valid,
  output logic [SRC_W-1:0]        win_idx
);
  import xarb_pkg::*;

  logic [TS_W-1:0] best_age;
  logic [TS_W-1:0] cur_age;

  // Strictly-greater replacement keeps the lower index on equal age.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    best_age  = '0;
    cur_age   = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      cur_age = TS_W'(stamp_age(32'(now), 32'(cand_ts[i*TS_W +: TS_W]), TS_W));
      if (cand_valid[i] && (!win_valid || cur_age > best_age)) begin
        win_valid = 1'b1;
        win_idx   = SRC_W'(i);
        best_age  = cur_age;
      end
    end
  end
endmodule

// File: rtl/xbar_age_arb.sv
module xbar_age_arb #(
  parameter int NUM_REQ = 8,
  parameter int BEAT_W  = 128,
  parameter int TS_W    = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_REQ-1:0]            req_valid,
  output logic [NUM_REQ-1:0]            req_ready,
  input  logic [NUM_REQ-1:0]            req_kind,
  input  logic [NUM_REQ*2*BEAT_W-1:0]   req_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [BEAT_W-1:0]             out_data,
  output logic                          out_last,
  output logic [$clog2(NUM_REQ)-1:0]    out_src
);
  import xarb_pkg::*;

  localparam int SRC_W = $clog2(NUM_REQ);
  localparam int PAY_W = 2 * BEAT_W;

  logic [TS_W-1:0]         ts_now;
  logic [NUM_REQ-1:0]      q_full, head_valid, head_kind, pop_vec;
  logic [PAY_W-1:0]        head_data [NUM_REQ];
  logic [NUM_REQ*TS_W-1:0] head_ts;

  logic                    win_valid;
  logic [SRC_W-1:0]        win_idx;
  logic                    lock_q;
  logic [SRC_W-1:0]        lock_src_q;

  // Named pipeline events, used by the checker.
  logic                    slot_free;
  logic                    grant_fire;
  logic                    beat1_fire;
  logic [SRC_W-1:0]        sel_src;
  logic [PAY_W-1:0]        sel_pay;

  always_ff @(posedge clk) begin
    if (!rst_n) ts_now <= '0;
    else        ts_now <= ts_now + 1'b1;
  end

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
    xarb_pair_fifo #(.PAY_W(PAY_W), .TS_W(TS_W)) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (req_valid[g] & ~q_full[g]),
      .push_kind  (req_kind[g]),
      .push_data  (req_data[g*PAY_W +: PAY_W]),
      .push_ts    (ts_now),
      .pop        (pop_vec[g]),
      .head_valid (head_valid[g]),
      .head_kind  (head_kind[g]),
      .head_data  (head_data[g]),
      .head_ts    (head_ts[g*TS_W +: TS_W]),
      .full       (q_full[g])
    );
    assign pop_vec[g] = (beat1_fire && lock_src_q == SRC_W'(g)) ||
                        (grant_fire && win_idx == SRC_W'(g) &&
                         head_kind[g] == KIND_WORD);
  end

  assign req_ready = ~q_full;

  xarb_oldest_pick #(.NUM_REQ(NUM_REQ), .TS_W(TS_W), .SRC_W(SRC_W)) u_pick (
    .now        (ts_now),
    .cand_valid (head_valid & ~({NUM_REQ{lock_q}})),
    .cand_ts    (head_ts),
    .win_valid  (win_valid),
    .win_idx    (win_idx)
  );

  assign slot_free  = !out_valid || out_ready;
  assign beat1_fire = slot_free && lock_q;
  assign grant_fire = slot_free && !lock_q && win_valid;
  assign sel_src    = lock_q ? lock_src_q : win_idx;
  assign sel_pay    = head_data[sel_src];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_last   <= 1'b0;
      out_src    <= '0;
      lock_q     <= 1'b0;
      lock_src_q <= '0;
    end else if (beat1_fire) begin
      out_valid <= 1'b1;
      out_last  <= 1'b1;
      out_src   <= lock_src_q;
      lock_q    <= 1'b0;
    end else if (grant_fire) begin
      out_valid  <= 1'b1;
      out_last   <= (head_kind[win_idx] == KIND_WORD);
      out_src    <= win_idx;
      lock_q     <= (head_kind[win_idx] == KIND_LINE);
      lock_src_q <= win_idx;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (beat1_fire)      out_data <= sel_pay[PAY_W-1:BEAT_W];
    else if (grant_fire) out_data <= sel_pay[BEAT_W-1:0];
  end
endmodule

// File: rtl/xbar_age_arb_chk.sv
module xbar_age_arb_chk #(
  parameter int NUM_REQ = 8,
  parameter int BEAT_W  = 128
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic                       out_last,
  input logic [$clog2(NUM_REQ)-1:0] out_src,
  input logic [BEAT_W-1:0]          out_data,
  input logic [NUM_REQ-1:0]         req_ready,
  input logic [NUM_REQ-1:0]         pop_vec,
  input logic                       lock_q
);
  // R7: a stalled beat is held unchanged
  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) &&
                                $stable(out_src) && $stable(out_last));

  // R5: accepted first beat is followed at once by the last beat, same source
  p_beat_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid && out_last && $stable(out_src));

  // R6: port stays reserved while a first beat is on the output
  p_port_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |-> lock_q);

  // R6: queues release at most one packet per cycle
  p_single_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop_vec));

  // R9: port leaves reset idle with every queue open
  p_reset_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid && (req_ready == {NUM_REQ{1'b1}}));
endmodule

bind xbar_age_arb xbar_age_arb_chk #(.NUM_REQ(NUM_REQ), .BEAT_W(BEAT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_last  (out_last),
  .out_src   (out_src),
  .out_data  (out_data),
  .req_ready (req_ready),
  .pop_vec   (pop_vec),
  .lock_q    (lock_q)
);

// File: tb/xbar_age_arb_bench.sv
module xbar_age_arb_bench;
  localparam int N      = 8;
  localparam int BW     = 128;
  localparam int SW     = $clog2(N);

  typedef struct packed {
    logic [SW-1:0] src;
    logic          last;
    logic [BW-1:0] data;
  } beat_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N-1:0]      req_valid = '0;
  logic [N-1:0]      req_ready;
  logic [N-1:0]      req_kind = '0;
  logic [N*2*BW-1:0] req_data = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [BW-1:0]     out_data;
  logic              out_last;
  logic [SW-1:0]     out_src;

  int    checks = 0;
  int    failures = 0;
  bit    finished = 0;
  int    rdy_mode = 0;          // 0 stall, 1 always ready, 2 pseudo-random
  logic [7:0] lfsr = 8'h5B;
  beat_t exp_q[$];

  always #4 clk = ~clk;         // 125 MHz

  xbar_age_arb u_xbar_age_arb (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_data(req_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last), .out_src(out_src)
  );

  function automatic logic [BW-1:0] mk_beat(input int tag, input int src, input int b);
    return {32'(tag), 32'(src), 32'(b), 32'hC0DE_0000 ^ 32'(tag)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= (rdy_mode == 1) || (rdy_mode == 2 && lfsr[0]);
  end

  // One push cycle; expected beats are queued in (cycle, index) order.
  task automatic push_cycle(input logic [N-1:0] mask, input logic [N-1:0] kind, input int tag);
    @(negedge clk);
    req_valid = mask;
    req_kind  = kind;
    for (int i = 0; i < N; i++) begin
      req_data[i*2*BW +: BW]      = mk_beat(tag, i, 0);
      req_data[i*2*BW + BW +: BW] = mk_beat(tag, i, 1);
      if (mask[i] && req_ready[i]) begin
        exp_q.push_back('{src: SW'(i), last: !kind[i], data: mk_beat(tag, i, 0)});
        if (kind[i]) exp_q.push_back('{src: SW'(i), last: 1'b1, data: mk_beat(tag, i, 1)});
      end
    end
    @(negedge clk);
    req_valid = '0;
  endtask

  task automatic drain();
    for (int k = 0; k < 400; k++) begin
      if (exp_q.size() == 0 && !out_valid) break;
      @(negedge clk);
    end
    #2;
    check(exp_q.size() == 0 && !out_valid, "R1/R8", "queue drained",
          BW'(exp_q.size()), '0);
  endtask

  // Monitor: scoreboard compare, stall hold and back-to-back beats.
  bit            prev_first = 0;
  bit            prev_stall = 0;
  beat_t         prev_beat;
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (prev_first)
        check(out_valid && out_last && out_src == prev_beat.src, "R5",
              "second beat back-to-back", BW'({out_valid, out_last, out_src}),
              BW'({1'b1, 1'b1, prev_beat.src}));
      if (prev_stall)
        check(out_valid && out_data == prev_beat.data && out_src == prev_beat.src &&
              out_last == prev_beat.last, "R7", "held while stalled", out_data, prev_beat.data);
      prev_first = 0;
      prev_stall = 0;
      prev_beat  = '{src: out_src, last: out_last, data: out_data};
      if (out_valid && !out_ready) prev_stall = 1;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1", "unexpected beat", out_data, '0);
        end else begin
          beat_t e;
          e = exp_q.pop_front();
          check(out_src == e.src && out_last == e.last && out_data == e.data,
                "R3/R4/R6/R8/R10", "beat order and payload",
                BW'({out_src, out_last, out_data[63:0]}), BW'({e.src, e.last, e.data[63:0]}));
        end
        if (!out_last) prev_first = 1;
      end
    end
  end

  initial begin
    for (int c = 0; c < 100000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && req_ready == '1, "R9", "state in reset",
          BW'({out_valid, req_ready}), BW'({1'b0, {N{1'b1}}}));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!out_valid && req_ready == '1, "R9", "state after reset",
          BW'({out_valid, req_ready}), BW'({1'b0, {N{1'b1}}}));

    // R2: three-step latency on an idle port
    rdy_mode = 1;
    repeat (2) @(negedge clk);
    push_cycle(8'b0000_1000, 8'h00, 1);
    #1;
    check(!out_valid, "R2", "arbitration cycle idle", BW'(out_valid), '0);
    @(negedge clk);
    #1;
    check(out_valid && out_src == 3, "R2", "transmit cycle", BW'({out_valid, out_src}),
          BW'({1'b1, 3'd3}));
    drain();

    // R1 and R8: third push refused, FIFO order kept, stalled output
    rdy_mode = 0;
    repeat (2) @(negedge clk);
    push_cycle(8'b0000_0001, 8'h00, 10);
    push_cycle(8'b0000_0001, 8'h01, 11);
    push_cycle(8'b0000_0001, 8'h00, 12);
    #1;
    check(req_ready[0] == 1'b0, "R1", "ready low with two queued", BW'(req_ready[0]), '0);
    push_cycle(8'b0000_0001, 8'h00, 13);
    rdy_mode = 1;
    drain();

    // R4 tie, then R3 age beating lower index, with a line packet (R5/R6)
    rdy_mode = 0;
    repeat (2) @(negedge clk);
    push_cycle(8'b0010_0100, 8'b0010_0000, 20);
    push_cycle(8'b0100_0000, 8'b0100_0000, 21);
    push_cycle(8'b0000_0010, 8'h00, 22);
    push_cycle(8'b1001_0000, 8'b1000_0000, 23);
    rdy_mode = 2;
    drain();

    // Streaming mix under random back-pressure
    for (int t = 0; t < 60; t++) begin
      push_cycle(lfsr ^ 8'(t * 37), 8'(t * 91) ^ {lfsr[3:0], lfsr[7:4]}, 100 + t);
    end
    drain();

    rdy_mode = 1;
    for (int t = 0; t < 30; t++) push_cycle(8'hFF, 8'(t * 53), 300 + t);
    drain();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule